// File: doc/BRIEF.md
# Extended 64-bit Integer ALU

This block computes one integer result per accepted operation for a 64-bit scalar pipeline. A 7-bit operation code picks the function, and its top three bits name an operation group. The groups cover shifts and rotates, single-bit edits, 32-bit word forms, an add family with scaled and right-shifted addends, subtraction with comparisons and min/max, bitwise logic with inverted operands, byte and bit reordering with packing, logic results narrowed to one bit or a half-word, and conditional-branch evaluation.

The datapath is combinational. Its result and branch-taken flag are captured in an output register whenever the input is marked valid. The valid mark reaches the output one cycle later. Opcodes that name no operation produce a zero result and a low flag.

Top module: `int_xalu`

## Requirements
- R1: While `rst_n` is low at a clock edge, `out_valid`, `result` and `taken` become 0.
- R2: `out_valid` equals `in_valid` from the previous cycle. `result` and `taken` load only on a cycle with `in_valid` high, and otherwise hold their values.
- R3: Group 000 shifts and rotates use `src_b[5:0]` as the amount. 0x01 shifts left, 0x05 shifts right logically, 0x07 shifts right arithmetically, 0x09 rotates left and 0x0B rotates right. 0x00 shifts the zero-extended `src_a[31:0]` left.
- R4: The single-bit ops use `src_b[5:0]` as a bit index. 0x02 clears that bit of `src_a`, 0x03 sets it, 0x04 flips it, and 0x06 returns it in bit 0 with all other bits zero.
- R5: The word ops 0x10 (add), 0x11 (add `src_a[0]`), 0x12 (subtract), 0x18 (shift left), 0x19 (logical right), 0x1A (arithmetic right), 0x1C (rotate left) and 0x1D (rotate right) work on the low 32 bits. They use `src_b[4:0]` as the amount and sign-extend the 32-bit outcome to 64 bits.
- R6: From the 64-bit sum `src_a+src_b`, 0x14 returns bit 0, 0x15 returns bits [7:0], 0x16 zero-extends bits [15:0] and 0x17 sign-extends bits [15:0].
- R7: The add group gives the following results. 0x20 adds the zero-extended `src_a[31:0]` to `src_b`. 0x21 adds `src_a` and `src_b`. 0x22 adds `src_a[0]` to `src_b`. 0x24 to 0x27 add `src_a` shifted right logically by 29, 30, 31 and 32. 0x29, 0x2B, 0x2D and 0x2F add `src_a` shifted left by 1, 2, 3 and 4. 0x28, 0x2A and 0x2C add the zero-extended low word shifted left by 1, 2 and 3.
- R8: 0x30 returns `src_a-src_b`. 0x31 and 0x32 return 1 when `src_a` is below `src_b`, compared unsigned and signed respectively. 0x34 and 0x36 return the larger operand, and 0x35 and 0x37 the smaller, compared unsigned and signed respectively.
- R9: 0x40 and, 0x41 and-not (`src_a & ~src_b`), 0x42 or, 0x43 or-not, 0x44 xor, 0x45 xnor. 0x46 sets each byte of `src_a` to 0xFF if it is non-zero and to 0 otherwise. 0x48 and 0x4A sign-extend the low byte and low half of `src_a`. 0x49 returns `{src_b[7:0],src_a[7:0]}` zero-extended. 0x4B returns `{src_b[15:0],src_a[15:0]}` sign-extended. 0x50 reverses the bits inside each byte, 0x51 reverses the byte order, and 0x52 returns `{src_b[31:0],src_a[31:0]}`.
- R10: Opcodes 0x60 to 0x67 apply and, or, xor or byte-or-combine, selected by opcode bits [2:1] as 00, 01, 10 and 11. An even opcode keeps only bit 0 of that outcome. An odd opcode keeps its low 16 bits, zero-extended.
- R11: Branch opcodes 0x70 (equal), 0x72 (not equal), 0x78 (signed less), 0x7A (signed greater-or-equal), 0x7C (unsigned less) and 0x7E (unsigned greater-or-equal) set `taken` to the outcome and give a zero result. Every non-branch opcode gives `taken` = 0.
- R12: Every opcode not listed in R3 to R11 gives a zero result and `taken` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 7 | Operation code, group in bits [6:4] |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand, also the shift amount or bit index |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered result |
| taken | output | 1 | Registered branch outcome |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and the hold of the output when no operation arrives;
- `taken` stays low outside the branch group, and branches give a zero result;
- word results are sign-extended across their upper 33 bits;
- bit-narrowed logic results leave bits [63:1] clear.

The exact arithmetic of each opcode can only be shown by the bench's scenarios. The bench sweeps all 128 opcodes against operand pairs that hit shift amounts 0, 31, 32 and 63, signed extremes, word carry-out and equal operands. That covers rotate wraparound, the sign of word results and the encodings that are undefined.

// File: rtl/xalu_pkg.sv
`timescale 1ns/1ps
// Shared group encoding for the extended ALU. The groups sit in opcode bits [6:4].
package xalu_pkg;
    localparam int unsigned OP_W       = 7;
    localparam int unsigned SRADD_BASE = 29;  // smallest right-shift used by the shifted-add ops

    typedef enum logic [2:0] {
        GRP_SHIFT  = 3'b000,
        GRP_WORD   = 3'b001,
        GRP_ADD    = 3'b010,
        GRP_SUB    = 3'b011,
        GRP_MISC0  = 3'b100,
        GRP_MISC1  = 3'b101,
        GRP_REDUCE = 3'b110,
        GRP_BRANCH = 3'b111
    } grp_e;
endpackage

// File: rtl/xalu_shift.sv
`timescale 1ns/1ps
// Group 000: full-width shifts and rotates, plus single-bit clear, set, flip and extract.
// Assumes DATA_W is a power of two. amt carries the low log2(DATA_W) bits of the second operand.
module xalu_shift #(
    parameter int unsigned DATA_W = 64
) (
    input  logic [3:0]                  sub_op,
    input  logic [DATA_W-1:0]           a,
    input  logic [$clog2(DATA_W)-1:0]   amt,
    output logic [DATA_W-1:0]           res
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned SH_W   = $clog2(DATA_W);

    logic [DATA_W-1:0]   one_hot, a_zext, rot_l, rot_r;
    logic [2*DATA_W-1:0] dbl;
    logic [SH_W-1:0]     neg_amt;

    assign one_hot = {{(DATA_W-1){1'b0}}, 1'b1} << amt;
    assign a_zext  = {{HALF_W{1'b0}}, a[HALF_W-1:0]};
    assign dbl     = {a, a};
    assign neg_amt = {SH_W{1'b0}} - amt;
    assign rot_r   = dbl[amt +: DATA_W];
    assign rot_l   = dbl[neg_amt +: DATA_W];

    // Select the group-000 operation.
    always_comb begin
        case (sub_op)
            4'h0:    res = a_zext << amt;
            4'h1:    res = a << amt;
            4'h2:    res = a & ~one_hot;
            4'h3:    res = a | one_hot;
            4'h4:    res = a ^ one_hot;
            4'h5:    res = a >> amt;
            4'h6:    res = {{(DATA_W-1){1'b0}}, |(a & one_hot)};
            4'h7:    res = $signed(a) >>> amt;
            4'h9:    res = rot_l;
            4'hB:    res = rot_r;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/xalu_arith.sv
`timescale 1ns/1ps
// Adder-based groups: word ops, the add family, subtract/compare and branch evaluation.
// Assumes DATA_W is a power of two of at least 64. taken can rise only in the branch group.
module xalu_arith
    import xalu_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  grp_e                grp,
    input  logic [3:0]          sub_op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res,
    output logic                taken
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned SH_W   = $clog2(DATA_W);
    localparam int unsigned WSH_W  = SH_W - 1;
    localparam int unsigned HW     = 16;
    localparam int unsigned BW     = 8;

    function automatic logic [DATA_W-1:0] sext_w(input logic [HALF_W-1:0] v);
        return {{HALF_W{v[HALF_W-1]}}, v};
    endfunction

    logic [DATA_W-1:0]   fsum, diff, a_zext, lsb_a;
    logic [HALF_W-1:0]   wa, wb, wror, wrol;
    logic [2*HALF_W-1:0] wdbl;
    logic [WSH_W-1:0]    wamt, wneg;
    logic [SH_W-1:0]     sr_amt;
    logic                lt_s, lt_u, eq;

    assign fsum   = a + b;
    assign diff   = a - b;
    assign a_zext = {{HALF_W{1'b0}}, a[HALF_W-1:0]};
    assign lsb_a  = {{(DATA_W-1){1'b0}}, a[0]};
    assign wa     = a[HALF_W-1:0];
    assign wb     = b[HALF_W-1:0];
    assign wamt   = b[WSH_W-1:0];
    assign wneg   = {WSH_W{1'b0}} - wamt;
    assign wdbl   = {wa, wa};
    assign wror   = wdbl[wamt +: HALF_W];
    assign wrol   = wdbl[wneg +: HALF_W];
    assign sr_amt = SH_W'(SRADD_BASE) + SH_W'(sub_op[1:0]);
    assign lt_s   = $signed(a) < $signed(b);
    assign lt_u   = a < b;
    assign eq     = a == b;

    // Compute the result and the branch outcome of the selected adder-based group.
    always_comb begin
        res   = '0;
        taken = 1'b0;
        case (grp)
            GRP_WORD: begin
                case (sub_op)
                    4'h0: res = sext_w(wa + wb);
                    4'h1: res = sext_w(lsb_a[HALF_W-1:0] + wb);
                    4'h2: res = sext_w(wa - wb);
                    4'h4: res = {{(DATA_W-1){1'b0}}, fsum[0]};
                    4'h5: res = {{(DATA_W-BW){1'b0}}, fsum[BW-1:0]};
                    4'h6: res = {{(DATA_W-HW){1'b0}}, fsum[HW-1:0]};
                    4'h7: res = {{(DATA_W-HW){fsum[HW-1]}}, fsum[HW-1:0]};
                    4'h8: res = sext_w(wa << wamt);
                    4'h9: res = sext_w(wa >> wamt);
                    4'hA: res = sext_w($signed(wa) >>> wamt);
                    4'hC: res = sext_w(wrol);
                    4'hD: res = sext_w(wror);
                    default: res = '0;
                endcase
            end
            GRP_ADD: begin
                case (sub_op)
                    4'h0: res = a_zext + b;
                    4'h1: res = fsum;
                    4'h2: res = lsb_a + b;
                    4'h4, 4'h5, 4'h6, 4'h7: res = (a >> sr_amt) + b;
                    4'h8: res = (a_zext << 1) + b;
                    4'h9: res = (a << 1) + b;
                    4'hA: res = (a_zext << 2) + b;
                    4'hB: res = (a << 2) + b;
                    4'hC: res = (a_zext << 3) + b;
                    4'hD: res = (a << 3) + b;
                    4'hF: res = (a << 4) + b;
                    default: res = '0;
                endcase
            end
            GRP_SUB: begin
                case (sub_op)
                    4'h0: res = diff;
                    4'h1: res = {{(DATA_W-1){1'b0}}, lt_u};
                    4'h2: res = {{(DATA_W-1){1'b0}}, lt_s};
                    4'h4: res = lt_u ? b : a;
                    4'h5: res = lt_u ? a : b;
                    4'h6: res = lt_s ? b : a;
                    4'h7: res = lt_s ? a : b;
                    default: res = '0;
                endcase
            end
            GRP_BRANCH: begin
                // bits [3:2] pick the compare, bit 1 inverts it; bit 0 set or kind 01 is undefined
                if (!sub_op[0]) begin
                    case (sub_op[3:2])
                        2'b00:   taken = eq   ^ sub_op[1];
                        2'b10:   taken = lt_s ^ sub_op[1];
                        2'b11:   taken = lt_u ^ sub_op[1];
                        default: taken = 1'b0;
                    endcase
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/xalu_logic.sv
`timescale 1ns/1ps
// Logic groups: bitwise ops, extension, packing, reordering and bit/half-narrowed logic.
// Assumes DATA_W is a multiple of 8 and at least 64.
module xalu_logic
    import xalu_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  grp_e                grp,
    input  logic [3:0]          sub_op,
    input  logic [DATA_W-1:0]   a,
    input  logic [DATA_W-1:0]   b,
    output logic [DATA_W-1:0]   res
);
    localparam int unsigned HALF_W = DATA_W / 2;
    localparam int unsigned NBYTE  = DATA_W / 8;
    localparam int unsigned HW     = 16;
    localparam int unsigned BW     = 8;

    logic [DATA_W-1:0] orc, brev, bswap, red_src;

    for (genvar i = 0; i < NBYTE; i++) begin : g_byte
        assign orc[8*i +: 8]   = {8{|a[8*i +: 8]}};
        assign bswap[8*i +: 8] = a[DATA_W-8-8*i +: 8];
        for (genvar j = 0; j < 8; j++) begin : g_bit
            assign brev[8*i+j] = a[8*i+7-j];
        end
    end

    // Pick the logic outcome that the narrowed group reduces.
    always_comb begin
        case (sub_op[2:1])
            2'b00:   red_src = a & b;
            2'b01:   red_src = a | b;
            2'b10:   red_src = a ^ b;
            default: red_src = orc;
        endcase
    end

    // Select the result of the logic, pack or narrowed-logic operation.
    always_comb begin
        res = '0;
        case (grp)
            GRP_MISC0: begin
                case (sub_op)
                    4'h0: res = a & b;
                    4'h1: res = a & ~b;
                    4'h2: res = a | b;
                    4'h3: res = a | ~b;
                    4'h4: res = a ^ b;
                    4'h5: res = ~(a ^ b);
                    4'h6: res = orc;
                    4'h8: res = {{(DATA_W-BW){a[BW-1]}}, a[BW-1:0]};
                    4'h9: res = {{(DATA_W-HW){1'b0}}, b[BW-1:0], a[BW-1:0]};
                    4'hA: res = {{(DATA_W-HW){a[HW-1]}}, a[HW-1:0]};
                    4'hB: res = {{(DATA_W-2*HW){b[HW-1]}}, b[HW-1:0], a[HW-1:0]};
                    default: res = '0;
                endcase
            end
            GRP_MISC1: begin
                case (sub_op)
                    4'h0: res = brev;
                    4'h1: res = bswap;
                    4'h2: res = {b[HALF_W-1:0], a[HALF_W-1:0]};
                    default: res = '0;
                endcase
            end
            GRP_REDUCE: begin
                if (!sub_op[3])
                    res = sub_op[0] ? {{(DATA_W-HW){1'b0}}, red_src[HW-1:0]}
                                    : {{(DATA_W-1){1'b0}}, red_src[0]};
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/int_xalu.sv
`timescale 1ns/1ps
// Extended integer ALU with a registered output stage.
// The datapath is combinational. The output registers load when in_valid is high,
// and out_valid trails in_valid by one cycle. Reset is synchronous and active low.
module int_xalu
    import xalu_pkg::*;
#(
    parameter int unsigned DATA_W = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [OP_W-1:0]     op,
    input  logic [DATA_W-1:0]   src_a,
    input  logic [DATA_W-1:0]   src_b,
    output logic                out_valid,
    output logic [DATA_W-1:0]   result,
    output logic                taken
);
    localparam int unsigned SH_W   = $clog2(DATA_W);
    localparam int unsigned HALF_W = DATA_W / 2;

    grp_e              grp;
    logic [DATA_W-1:0] sh_res, ar_res, lg_res, nxt_res;
    logic              ar_taken;

    assign grp = grp_e'(op[6:4]);

    xalu_shift #(.DATA_W(DATA_W)) u_shift (
        .sub_op (op[3:0]),
        .a      (src_a),
        .amt    (src_b[SH_W-1:0]),
        .res    (sh_res)
    );

    xalu_arith #(.DATA_W(DATA_W)) u_arith (
        .grp    (grp),
        .sub_op (op[3:0]),
        .a      (src_a),
        .b      (src_b),
        .res    (ar_res),
        .taken  (ar_taken)
    );

    xalu_logic #(.DATA_W(DATA_W)) u_logic (
        .grp    (grp),
        .sub_op (op[3:0]),
        .a      (src_a),
        .b      (src_b),
        .res    (lg_res)
    );

    // Route the result of the unit that owns the opcode group.
    always_comb begin
        case (grp)
            GRP_SHIFT:                        nxt_res = sh_res;
            GRP_WORD, GRP_ADD, GRP_SUB:       nxt_res = ar_res;
            GRP_MISC0, GRP_MISC1, GRP_REDUCE: nxt_res = lg_res;
            default:                          nxt_res = '0;
        endcase
    end

    // Capture the result on valid input; clear everything on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            result    <= '0;
            taken     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt_res;
                taken  <= ar_taken;
            end
        end
    end

    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(result) && $stable(taken)));
    p_taken_branch_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[6:4] != 3'b111) |=> !taken);
    p_branch_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[6:4] == 3'b111) |=> (result == '0));
    p_word_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op inside {7'h10, 7'h11, 7'h12, 7'h18, 7'h19, 7'h1A, 7'h1C, 7'h1D}))
        |=> ((result[DATA_W-1:HALF_W-1] == '0) || (&result[DATA_W-1:HALF_W-1])));
    p_reduce_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op[6:3] == 4'b1100 && !op[0]) |=> (result[DATA_W-1:1] == '0));
endmodule

// File: tb/int_xalu_test.sv
`timescale 1ns/1ps
module int_xalu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [6:0]  op = 7'h0;
    logic [63:0] src_a = 64'h0, src_b = 64'h0;
    logic        out_valid, taken;
    logic [63:0] result;
    int          n_tests = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;  // 125 MHz

    int_xalu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result), .taken(taken)
    );

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] sx32(input logic [31:0] w);
        return {{32{w[31]}}, w};
    endfunction

    // Independent model built from the requirements.
    task automatic model(input logic [6:0] o, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic t, output logic defd);
        logic [5:0]  s;
        logic [4:0]  ws;
        logic [63:0] x;
        s = b[5:0]; ws = b[4:0]; r = 64'h0; t = 1'b0; defd = 1'b1;
        case (o)
            7'h00: r = {32'h0, a[31:0]} << s;
            7'h01: r = a << s;
            7'h02: r = a & ~(64'h1 << s);
            7'h03: r = a | (64'h1 << s);
            7'h04: r = a ^ (64'h1 << s);
            7'h05: r = a >> s;
            7'h06: r = {63'h0, a[s]};
            7'h07: r = $unsigned($signed(a) >>> s);
            7'h09: r = (s == 0) ? a : ((a << s) | (a >> (7'd64 - {1'b0, s})));
            7'h0B: r = (s == 0) ? a : ((a >> s) | (a << (7'd64 - {1'b0, s})));
            7'h10: r = sx32(a[31:0] + b[31:0]);
            7'h11: r = sx32({31'h0, a[0]} + b[31:0]);
            7'h12: r = sx32(a[31:0] - b[31:0]);
            7'h14: begin x = a + b; r = {63'h0, x[0]}; end
            7'h15: begin x = a + b; r = {56'h0, x[7:0]}; end
            7'h16: begin x = a + b; r = {48'h0, x[15:0]}; end
            7'h17: begin x = a + b; r = {{48{x[15]}}, x[15:0]}; end
            7'h18: r = sx32(a[31:0] << ws);
            7'h19: r = sx32(a[31:0] >> ws);
            7'h1A: r = sx32($unsigned($signed(a[31:0]) >>> ws));
            7'h1C: r = sx32((ws == 0) ? a[31:0] : ((a[31:0] << ws) | (a[31:0] >> (6'd32 - {1'b0, ws}))));
            7'h1D: r = sx32((ws == 0) ? a[31:0] : ((a[31:0] >> ws) | (a[31:0] << (6'd32 - {1'b0, ws}))));
            7'h20: r = {32'h0, a[31:0]} + b;
            7'h21: r = a + b;
            7'h22: r = {63'h0, a[0]} + b;
            7'h24: r = (a >> 29) + b;
            7'h25: r = (a >> 30) + b;
            7'h26: r = (a >> 31) + b;
            7'h27: r = (a >> 32) + b;
            7'h28: r = ({32'h0, a[31:0]} << 1) + b;
            7'h29: r = (a << 1) + b;
            7'h2A: r = ({32'h0, a[31:0]} << 2) + b;
            7'h2B: r = (a << 2) + b;
            7'h2C: r = ({32'h0, a[31:0]} << 3) + b;
            7'h2D: r = (a << 3) + b;
            7'h2F: r = (a << 4) + b;
            7'h30: r = a - b;
            7'h31: r = {63'h0, a < b};
            7'h32: r = {63'h0, $signed(a) < $signed(b)};
            7'h34: r = (a > b) ? a : b;
            7'h35: r = (a > b) ? b : a;
            7'h36: r = ($signed(a) > $signed(b)) ? a : b;
            7'h37: r = ($signed(a) > $signed(b)) ? b : a;
            7'h40: r = a & b;
            7'h41: r = a & ~b;
            7'h42: r = a | b;
            7'h43: r = a | ~b;
            7'h44: r = a ^ b;
            7'h45: r = ~(a ^ b);
            7'h46: for (int i = 0; i < 8; i++) r[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
            7'h48: r = {{56{a[7]}}, a[7:0]};
            7'h49: r = {48'h0, b[7:0], a[7:0]};
            7'h4A: r = {{48{a[15]}}, a[15:0]};
            7'h4B: r = {{32{b[15]}}, b[15:0], a[15:0]};
            7'h50: for (int i = 0; i < 64; i++) r[i] = a[(i & ~7) + (7 - (i & 7))];
            7'h51: for (int i = 0; i < 8; i++) r[8*i +: 8] = a[8*(7-i) +: 8];
            7'h52: r = {b[31:0], a[31:0]};
            7'h60, 7'h61, 7'h62, 7'h63, 7'h64, 7'h65, 7'h66, 7'h67: begin
                case (o[2:1])
                    2'd0: x = a & b;
                    2'd1: x = a | b;
                    2'd2: x = a ^ b;
                    default: for (int i = 0; i < 8; i++) x[8*i +: 8] = (a[8*i +: 8] != 0) ? 8'hFF : 8'h00;
                endcase
                r = o[0] ? {48'h0, x[15:0]} : {63'h0, x[0]};
            end
            7'h70: t = (a == b);
            7'h72: t = (a != b);
            7'h78: t = ($signed(a) < $signed(b));
            7'h7A: t = !($signed(a) < $signed(b));
            7'h7C: t = (a < b);
            7'h7E: t = !(a < b);
            default: defd = 1'b0;
        endcase
    endtask

    function automatic string req_of(input logic [6:0] o, input logic defd);
        if (!defd) return "R12";
        case (o[6:4])
            3'd0: return (o inside {7'h02, 7'h03, 7'h04, 7'h06}) ? "R4" : "R3";
            3'd1: return (o inside {7'h14, 7'h15, 7'h16, 7'h17}) ? "R6" : "R5";
            3'd2: return "R7";
            3'd3: return "R8";
            3'd4, 3'd5: return "R9";
            3'd6: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic pick(input int k, output logic [63:0] a, output logic [63:0] b);
        case (k)
            0: begin a = 64'h8000_0000_8000_0001; b = 64'h0; end
            1: begin a = 64'hFEDC_BA98_7654_3210; b = 64'h0000_0000_0000_0025; end
            2: begin a = 64'h0123_4567_89AB_CDEF; b = 64'hFFFF_FFFF_FFFF_FFFF; end
            3: begin a = 64'h7FFF_FFFF_FFFF_FFFF; b = 64'h8000_0000_0000_0000; end
            4: begin a = 64'h0000_0000_FFFF_FFFF; b = 64'h0000_0000_0000_0001; end
            5: begin a = 64'hA5A5_0000_5A5A_00FF; b = 64'hA5A5_0000_5A5A_00FF; end
            6: begin a = 64'hFFFF_FFFF_FFFF_FFFE; b = 64'h0000_0000_0000_0020; end
            default: begin a = 64'h0000_0000_0000_0001; b = 64'hFFFF_FFFF_FFFF_FFFE; end
        endcase
    endtask

    initial begin
        #1_600_000;
        n_tests++; n_fail++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [63:0] a, b, er;
        logic        et, defd;
        // R1: reset clears the outputs even with valid input present
        in_valid = 1'b1; op = 7'h21; src_a = 64'h5; src_b = 64'h6;
        repeat (3) @(negedge clk);
        check("R1", "out_valid in reset", {63'h0, out_valid}, 64'h0);
        check("R1", "result in reset", result, 64'h0);
        check("R1", "taken in reset", {63'h0, taken}, 64'h0);
        in_valid = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R2", "out_valid idle", {63'h0, out_valid}, 64'h0);

        // Sweep of every opcode against each operand pair (R3 to R12)
        for (int o = 0; o < 128; o++) begin
            for (int k = 0; k < 8; k++) begin
                pick(k, a, b);
                in_valid = 1'b1; op = 7'(o); src_a = a; src_b = b;
                @(negedge clk);
                model(7'(o), a, b, er, et, defd);
                check(req_of(7'(o), defd), $sformatf("result op=%h k=%0d", o, k), result, er);
                check((o >= 112 && defd) ? "R11" : req_of(7'(o), defd),
                      $sformatf("taken op=%h k=%0d", o, k), {63'h0, taken}, {63'h0, et});
                check("R2", "out_valid after valid", {63'h0, out_valid}, 64'h1);
            end
        end

        // R2: hold when no valid input arrives
        in_valid = 1'b1; op = 7'h21; src_a = 64'h5; src_b = 64'h7;
        @(negedge clk);
        check("R2", "add before hold", result, 64'hC);
        in_valid = 1'b0; op = 7'h70; src_a = 64'h9; src_b = 64'h9;
        @(negedge clk);
        check("R2", "out_valid drop", {63'h0, out_valid}, 64'h0);
        check("R2", "result held", result, 64'hC);
        check("R2", "taken held", {63'h0, taken}, 64'h0);
        @(negedge clk);
        check("R2", "result still held", result, 64'hC);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule